// File: doc/BRIEF.md
# Multichannel Frame Alignment Controller

This block removes the skew between up to eight receive lanes, organised as two quads of four. Each lane carries one data word per clock together with a frame-pulse flag marking a frame boundary. Lanes that take part in alignment wait for their frame pulse, then buffer words from the pulse word on in a small per-lane FIFO. Once every enabled lane of an alignment group has buffered its pulse word, all members of the group start reading in the same cycle. After that, the lanes present word-aligned streams.

Every lane carries a 2-bit mode that chooses its group: standalone, pair, quad or all eight lanes. Each lane also has a sync enable, which decides whether its frame pulse gates the group. Every pair, every quad and the eight-lane group has its own resync input, which acts on a rising edge only. Every group reports an aligned flag and a sticky error flag. The error flag is raised when a lane's FIFO runs out of room before the group is released. If the modes are set while reset is held, the first frame pulses after reset align the groups without any resync.

Top module: `mc_frame_align`

## Requirements
- R1: While rst is high, all out_valid bits and all group aligned and error outputs are 0, and they are still 0 on the first clock after rst falls.
- R2: Lane l takes its mode from lane_mode[2l+1:2l]: 00 standalone, 01 pair, 10 quad, 11 all eight. The pairs are lanes {0,1},{2,3},{4,5},{6,7}, with pair_aligned/pair_err/resync_pair bit i covering lanes 2i and 2i+1. The quads are lanes 0-3 (bit 0) and lanes 4-7 (bit 1). A group's status depends only on lanes whose mode selects that group.
- R3: Let edge c be the clock edge at which the last enabled member samples its frame pulse. The group's aligned output is 1 after edge c+1. Every member's out_valid rises together after edge c+2, showing that lane's pulse word. After that, each member outputs one consecutive word per clock.
- R4: A skew of up to DEPTH-2 cycles between the earliest and the latest enabled member is absorbed without raising the group error.
- R5: A member whose sync_en bit is 0 does not gate the group, which aligns on its enabled members alone.
- R6: If an enabled member is DEPTH-1 or more cycles earlier than the last enabled member, its FIFO fills and the group error goes to 1. The error stays 1 until that group's resync.
- R7: A 0-to-1 change on a group's resync input clears that group's aligned and error outputs at the next edge, and restarts its members so that they wait for fresh frame pulses, which then align as in R3. Holding the resync input at 1 causes no further restart.
- R8: A resync of one group leaves the outputs and status of every other group unchanged.
- R9: A lane in mode 00 outputs, after edge e, the word it sampled at edge e, with out_valid 1, independent of any group.
- R10: A member with sync_en 0 buffers from its own frame pulse on. Its out_valid is 1 only once its group is aligned and its FIFO holds a word, so a disabled member that never sees a pulse never outputs a valid word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | LANES*DW | Per-lane input words, lane l at bits [l*DW +: DW] |
| in_fp | input | LANES | Per-lane frame pulse flag, qualifies the word of the same cycle |
| lane_mode | input | 2*LANES | Per-lane alignment mode, lane l at bits [2l+1:2l] |
| sync_en | input | LANES | Per-lane enable of the frame pulse in its group's condition |
| resync_pair | input | 4 | Rising-edge resync for each lane pair |
| resync_quad | input | 2 | Rising-edge resync for each quad |
| resync_all | input | 1 | Rising-edge resync for the eight-lane group |
| out_data | output | LANES*DW | Per-lane aligned output words |
| out_valid | output | LANES | Per-lane output word valid |
| pair_aligned | output | 4 | Aligned status of each pair group |
| quad_aligned | output | 2 | Aligned status of each quad group |
| all_aligned | output | 1 | Aligned status of the eight-lane group |
| pair_err | output | 4 | Sticky FIFO-overflow error of each pair group |
| quad_err | output | 2 | Sticky FIFO-overflow error of each quad group |
| all_err | output | 1 | Sticky FIFO-overflow error of the eight-lane group |

## Verification
The hardest state to reach is a partial resync. One quad is restarted while a neighbouring pair keeps streaming, and a sync-disabled member of that quad later sees a pulse after its group has already been released. The stimulus programs mixed modes while reset is held and runs both groups to alignment. It then raises the quad resync and leaves it high, moves the quad's frame pulses later, and finally gives the disabled lane its first pulse. All of this happens while the scoreboard keeps comparing the pair's words cycle by cycle. Overflow is reached separately by spacing two pulses in one quad by exactly DEPTH-1 cycles, while the other quad uses DEPTH-2.

// File: rtl/fa_pkg.sv
package fa_pkg;

    localparam int LANES    = 8;
    localparam int LPQ      = 4;
    localparam int NPAIR    = LANES / 2;
    localparam int NQUAD    = LANES / LPQ;
    localparam int NGRP     = NPAIR + NQUAD + 1;
    localparam int GRP_ALL  = NGRP - 1;
    localparam int GW       = $clog2(NGRP);

    typedef enum logic [1:0] {
        AM_SOLO = 2'b00,
        AM_PAIR = 2'b01,
        AM_QUAD = 2'b10,
        AM_ALL  = 2'b11
    } amode_e;

    typedef struct packed {
        logic seen;
        logic ovf;
    } lane_stat_t;

    typedef struct packed {
        logic restart;
        logic go;
    } lane_ctl_t;

    // Group index: pairs first, then quads, then the eight-lane group.
    function automatic logic [GW-1:0] group_of(input logic [2:0] lane, input logic [1:0] m);
        case (amode_e'(m))
            AM_PAIR: return GW'(lane >> 1);
            AM_QUAD: return GW'(NPAIR) + GW'(lane >> 2);
            default: return GW'(GRP_ALL);
        endcase
    endfunction

endpackage

// File: rtl/fa_edge.sv
module fa_edge #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;

    generate
        for (genvar i = 0; i < W; i++) begin : g_chk
            assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
                rise[i] |=> !rise[i]);
        end
    endgenerate

endmodule

// File: rtl/fa_lane.sv
module fa_lane
    import fa_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bypass,
    input  lane_ctl_t     ctl,
    input  logic [DW-1:0] in_data,
    input  logic          in_fp,
    output logic [DW-1:0] out_data,
    output logic          out_valid,
    output lane_stat_t    stat
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          seen_q;
    logic          wr_try, wr, rd, full;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full   = (cnt_q == CW'(DEPTH));
        wr_try = !bypass && (seen_q || in_fp);
        rd     = !bypass && ctl.go && (cnt_q != '0);
        wr     = wr_try && (!full || rd);
    end

    assign stat.seen = seen_q;
    assign stat.ovf  = wr_try && full && !rd;

    always_ff @(posedge clk) begin
        if (wr) mem[wp_q] <= in_data;
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.restart || bypass) begin
            wp_q   <= '0;
            rp_q   <= '0;
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            if (wr) wp_q <= ptr_inc(wp_q);
            if (rd) rp_q <= ptr_inc(rp_q);
            cnt_q <= cnt_q + CW'(wr) - CW'(rd);
            if (in_fp) seen_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_data  <= '0;
            out_valid <= 1'b0;
        end else if (bypass) begin
            out_data  <= in_data;
            out_valid <= 1'b1;
        end else begin
            out_valid <= rd;
            if (rd) out_data <= mem[rp_q];
        end
    end

    assert_fifo_bound_R4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

    assert_bypass_follow_R9: assert property (@(posedge clk) disable iff (rst)
        (bypass && $past(bypass) && !$past(rst)) |-> (out_valid && out_data == $past(in_data)));

    assert_valid_needs_go_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !bypass && !$past(bypass) && !$past(rst)) |-> $past(ctl.go));

    assert_seen_clear_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(seen_q) |-> $past(ctl.restart || bypass));

endmodule

// File: rtl/fa_groups.sv
module fa_groups
    import fa_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [LANES-1:0][1:0]       mode,
    input  logic [LANES-1:0]            sync_en,
    input  lane_stat_t [LANES-1:0]      stat,
    input  logic [NGRP-1:0]             rise,
    output logic [NGRP-1:0]             aligned,
    output logic [NGRP-1:0]             err,
    output lane_ctl_t [LANES-1:0]       ctl
);
    logic [NGRP-1:0][LANES-1:0] member;
    logic [NGRP-1:0]            ready, anyen, hit, go;
    logic [NGRP-1:0]            aligned_q, err_q;

    always_comb begin
        for (int g = 0; g < NGRP; g++) begin
            for (int l = 0; l < LANES; l++) begin
                member[g][l] = (mode[l] != AM_SOLO) &&
                               (group_of(3'(l), mode[l]) == GW'(g));
            end
        end
    end

    always_comb begin
        for (int g = 0; g < NGRP; g++) begin
            ready[g] = 1'b1;
            anyen[g] = 1'b0;
            hit[g]   = 1'b0;
            for (int l = 0; l < LANES; l++) begin
                if (member[g][l] && sync_en[l]) begin
                    anyen[g] = 1'b1;
                    if (!stat[l].seen) ready[g] = 1'b0;
                    if (stat[l].ovf)   hit[g]   = 1'b1;
                end
            end
            go[g] = ready[g] && anyen[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            aligned_q <= '0;
            err_q     <= '0;
        end else begin
            for (int g = 0; g < NGRP; g++) begin
                if (rise[g]) begin
                    aligned_q[g] <= 1'b0;
                    err_q[g]     <= 1'b0;
                end else begin
                    aligned_q[g] <= aligned_q[g] | go[g];
                    err_q[g]     <= err_q[g] | hit[g];
                end
            end
        end
    end

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_ctl
            logic [GW-1:0] grp;
            logic          act;
            assign grp            = group_of(3'(l), mode[l]);
            assign act            = (mode[l] != AM_SOLO);
            assign ctl[l].restart = act && rise[grp];
            assign ctl[l].go      = act && aligned_q[grp];
        end

        for (genvar g = 0; g < NGRP; g++) begin : g_chk
            assert_resync_clears_R7: assert property (@(posedge clk) disable iff (rst)
                rise[g] |=> (!aligned_q[g] && !err_q[g]));
            assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
                (err_q[g] && !rise[g]) |=> err_q[g]);
            assert_align_needs_ready_R3: assert property (@(posedge clk) disable iff (rst)
                $rose(aligned_q[g]) |-> $past(ready[g] && anyen[g]));
            assert_aligned_hold_R8: assert property (@(posedge clk) disable iff (rst)
                (aligned_q[g] && !rise[g]) |=> aligned_q[g]);
        end
    endgenerate

    assign aligned = aligned_q;
    assign err     = err_q;

endmodule

// File: rtl/mc_frame_align.sv
module mc_frame_align
    import fa_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [LANES*DW-1:0]   in_data,
    input  logic [LANES-1:0]      in_fp,
    input  logic [2*LANES-1:0]    lane_mode,
    input  logic [LANES-1:0]      sync_en,
    input  logic [NPAIR-1:0]      resync_pair,
    input  logic [NQUAD-1:0]      resync_quad,
    input  logic                  resync_all,
    output logic [LANES*DW-1:0]   out_data,
    output logic [LANES-1:0]      out_valid,
    output logic [NPAIR-1:0]      pair_aligned,
    output logic [NQUAD-1:0]      quad_aligned,
    output logic                  all_aligned,
    output logic [NPAIR-1:0]      pair_err,
    output logic [NQUAD-1:0]      quad_err,
    output logic                  all_err
);
    logic [LANES-1:0][1:0]  mode;
    logic [NGRP-1:0]        rs_lvl, rs_rise;
    logic [NGRP-1:0]        aligned, err;
    lane_stat_t [LANES-1:0] stat;
    lane_ctl_t  [LANES-1:0] ctl;

    assign rs_lvl = {resync_all, resync_quad, resync_pair};

    fa_edge #(.W(NGRP)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (rs_lvl),
        .rise (rs_rise)
    );

    fa_groups u_groups (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .sync_en (sync_en),
        .stat    (stat),
        .rise    (rs_rise),
        .aligned (aligned),
        .err     (err),
        .ctl     (ctl)
    );

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign mode[l] = lane_mode[2*l +: 2];

            fa_lane #(.DW(DW), .DEPTH(DEPTH)) u_lane (
                .clk       (clk),
                .rst       (rst),
                .bypass    (mode[l] == AM_SOLO),
                .ctl       (ctl[l]),
                .in_data   (in_data[l*DW +: DW]),
                .in_fp     (in_fp[l]),
                .out_data  (out_data[l*DW +: DW]),
                .out_valid (out_valid[l]),
                .stat      (stat[l])
            );
        end

        for (genvar l = 1; l < LANES; l++) begin : g_lock
            assert_lockstep_R3: assert property (@(posedge clk) disable iff (rst)
                (mode[l] != AM_SOLO && mode[l] == mode[l-1] &&
                 group_of(3'(l), mode[l]) == group_of(3'(l-1), mode[l-1]) &&
                 sync_en[l] && sync_en[l-1]) |-> (out_valid[l] == out_valid[l-1]));
        end
    endgenerate

    assign pair_aligned = aligned[NPAIR-1:0];
    assign quad_aligned = aligned[NPAIR +: NQUAD];
    assign all_aligned  = aligned[GRP_ALL];
    assign pair_err     = err[NPAIR-1:0];
    assign quad_err     = err[NPAIR +: NQUAD];
    assign all_err      = err[GRP_ALL];

endmodule

// File: tb/tb_mc_frame_align.sv
module tb_mc_frame_align;

    localparam int DW = 16;
    localparam int NL = 8;
    localparam int FAR = 32'h3fff_ffff;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NL*DW-1:0] in_data = '0;
    logic [NL-1:0]    in_fp = '0;
    logic [2*NL-1:0]  lane_mode = '0;
    logic [NL-1:0]    sync_en = '1;
    logic [3:0]       resync_pair = '0;
    logic [1:0]       resync_quad = '0;
    logic             resync_all = 1'b0;
    logic [NL*DW-1:0] out_data;
    logic [NL-1:0]    out_valid;
    logic [3:0]       pair_aligned, pair_err;
    logic [1:0]       quad_aligned, quad_err;
    logic             all_aligned, all_err;

    mc_frame_align #(.DW(DW), .DEPTH(8)) dut (
        .clk(clk), .rst(rst), .in_data(in_data), .in_fp(in_fp),
        .lane_mode(lane_mode), .sync_en(sync_en),
        .resync_pair(resync_pair), .resync_quad(resync_quad), .resync_all(resync_all),
        .out_data(out_data), .out_valid(out_valid),
        .pair_aligned(pair_aligned), .quad_aligned(quad_aligned), .all_aligned(all_aligned),
        .pair_err(pair_err), .quad_err(quad_err), .all_err(all_err)
    );

    always #5 clk = ~clk;

    typedef struct {
        int          cyc;
        int          lane;
        bit          v;
        logic [15:0] d;
        string       req;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   fpe [NL];
    int   tests = 0;
    int   fails = 0;

    function automatic logic [15:0] word(input int l, input int e);
        int k;
        k = e - fpe[l];
        return {4'(l), 12'(k)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (edge %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic summary_and_end();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // monitor (scoreboard pop) and driver of per-cycle lane words
    initial begin
        for (int l = 0; l < NL; l++) fpe[l] = FAR;
        forever begin
            @(negedge clk);
            for (int i = q.size() - 1; i >= 0; i--) begin
                if (q[i].cyc < cyc) begin
                    chk(1'b0, q[i].req, 32'(q[i].cyc), 32'(cyc));
                    q.delete(i);
                end else if (q[i].cyc == cyc) begin
                    if (q[i].v)
                        chk(out_valid[q[i].lane] && out_data[q[i].lane*DW +: DW] == q[i].d, q[i].req,
                            {15'(out_valid[q[i].lane]), 1'b0, out_data[q[i].lane*DW +: DW]},
                            {16'h2, q[i].d});
                    else
                        chk(!out_valid[q[i].lane], q[i].req, 32'(out_valid[q[i].lane]), 32'h0);
                    q.delete(i);
                end
            end
            cyc++;
            for (int l = 0; l < NL; l++) begin
                in_fp[l]              = (cyc == fpe[l]);
                in_data[l*DW +: DW]   = word(l, cyc);
            end
            if (cyc > 20000) begin
                chk(1'b0, "watchdog", 32'(cyc), 32'd20000);
                summary_and_end();
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_until(input int e);
        while (cyc < e) step();
    endtask

    task automatic push(input int c, input int l, input bit v, input logic [15:0] d, input string req);
        exp_t it;
        it.cyc = c; it.lane = l; it.v = v; it.d = d; it.req = req;
        q.push_back(it);
    endtask

    // expected group output: invalid at c+1, then pulse word and n-1 followers
    task automatic expect_group(input logic [7:0] mask, input int c, input int n, input string req);
        for (int l = 0; l < NL; l++) begin
            if (mask[l]) begin
                push(c + 1, l, 1'b0, '0, req);
                for (int k = 0; k < n; k++) push(c + 2 + k, l, 1'b1, {4'(l), 12'(k)}, req);
            end
        end
    endtask

    task automatic expect_bypass(input int l, input int from, input int n);
        for (int e = from; e < from + n; e++) push(e, l, 1'b1, word(l, e), "R9");
    endtask

    task automatic set_mode(input int l, input logic [1:0] m);
        lane_mode[2*l +: 2] = m;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        resync_pair = '0; resync_quad = '0; resync_all = 1'b0;
        for (int l = 0; l < NL; l++) fpe[l] = FAR;
        repeat (3) step();
        chk(out_valid == '0, "R1", 32'(out_valid), 32'h0);
        chk({pair_aligned, quad_aligned, all_aligned, pair_err, quad_err, all_err} == '0, "R1",
            32'({pair_aligned, quad_aligned, all_aligned, pair_err, quad_err, all_err}), 32'h0);
        rst = 1'b0;
        step();
        chk({pair_aligned, quad_aligned, all_aligned, pair_err, quad_err, all_err} == '0, "R1",
            32'({pair_aligned, quad_aligned, all_aligned, pair_err, quad_err, all_err}), 32'h0);
    endtask

    initial begin
        int b, c, cp0, cq1, r0;
        int sk [NL];

        // Scenario A: all eight lanes, skew up to 6 (R3, R4, R2)
        for (int l = 0; l < NL; l++) set_mode(l, 2'b11);
        sync_en = '1;
        do_reset();
        sk = '{3, 0, 6, 1, 5, 2, 4, 0};
        b = cyc + 4;
        for (int l = 0; l < NL; l++) fpe[l] = b + sk[l];
        c = b + 6;
        expect_group(8'hFF, c, 5, "R3");
        wait_until(c);
        chk(all_aligned == 1'b0, "R3", 32'(all_aligned), 32'h0);
        step();
        chk(all_aligned == 1'b1, "R3", 32'(all_aligned), 32'h1);
        wait_until(c + 10);
        chk(all_err == 1'b0, "R4", 32'(all_err), 32'h0);
        chk(pair_aligned == '0 && quad_aligned == '0, "R2", 32'({pair_aligned, quad_aligned}), 32'h0);

        // Scenario B: mixed modes, bypass lanes, disabled lane without pulse
        set_mode(0, 2'b01); set_mode(1, 2'b01);
        set_mode(2, 2'b00); set_mode(3, 2'b00);
        for (int l = 4; l < NL; l++) set_mode(l, 2'b10);
        sync_en = 8'b0111_1111;
        do_reset();
        b = cyc;
        fpe[0] = b + 6; fpe[1] = b + 4; fpe[2] = b; fpe[3] = b + 2;
        fpe[4] = b + 5; fpe[5] = b + 9; fpe[6] = b + 7;
        cp0 = b + 6;
        cq1 = b + 9;
        expect_group(8'b0000_0011, cp0, 4, "R2");
        expect_group(8'b0111_0000, cq1, 4, "R5");
        for (int e = cq1 + 1; e < cq1 + 6; e++) push(e, 7, 1'b0, '0, "R10");
        expect_bypass(2, b + 1, 12);
        expect_bypass(3, b + 1, 12);
        wait_until(cq1 + 1);
        chk(quad_aligned == 2'b10, "R5", 32'(quad_aligned), 32'h2);
        chk(pair_aligned == 4'b0001, "R2", 32'(pair_aligned), 32'h1);
        wait_until(b + 20);

        // Scenario C: resync of quad 1 only, level held
        r0 = cyc;
        resync_quad[1] = 1'b1;
        fpe[4] = r0 + 4; fpe[5] = r0 + 3; fpe[6] = r0 + 6;
        expect_group(8'b0111_0000, r0 + 6, 4, "R7");
        for (int e = r0 + 1; e < r0 + 10; e++) begin
            push(e, 0, 1'b1, {4'd0, 12'(e - (cp0 + 2))}, "R8");
            push(e, 1, 1'b1, {4'd1, 12'(e - (cp0 + 2))}, "R8");
        end
        chk(quad_aligned[1] == 1'b1, "R7", 32'(quad_aligned), 32'h2);
        step();
        chk(quad_aligned[1] == 1'b0, "R7", 32'(quad_aligned), 32'h0);
        chk(pair_aligned[0] == 1'b1, "R8", 32'(pair_aligned), 32'h1);
        wait_until(r0 + 7);
        chk(quad_aligned[1] == 1'b1, "R7", 32'(quad_aligned), 32'h2);
        // late pulse on the disabled lane after release
        fpe[7] = r0 + 12;
        push(r0 + 12, 7, 1'b0, '0, "R10");
        push(r0 + 13, 7, 1'b1, {4'd7, 12'd0}, "R10");
        push(r0 + 14, 7, 1'b1, {4'd7, 12'd1}, "R10");
        wait_until(r0 + 30);
        chk(quad_aligned[1] == 1'b1, "R7", 32'(quad_aligned), 32'h2);
        chk(pair_aligned[0] == 1'b1, "R8", 32'(pair_aligned), 32'h1);

        // Scenario D: overflow at skew DEPTH-1 in quad 0, skew DEPTH-2 in quad 1
        for (int l = 0; l < NL; l++) set_mode(l, 2'b10);
        sync_en = '1;
        do_reset();
        b = cyc;
        fpe[0] = b + 4; fpe[1] = b + 6; fpe[2] = b + 5; fpe[3] = b + 11;
        fpe[4] = b + 4; fpe[5] = b + 10; fpe[6] = b + 7; fpe[7] = b + 5;
        expect_group(8'hF0, b + 10, 4, "R4");
        wait_until(b + 11);
        chk(quad_err[0] == 1'b0, "R6", 32'(quad_err), 32'h0);
        step();
        chk(quad_err[0] == 1'b1, "R6", 32'(quad_err), 32'h1);
        wait_until(b + 30);
        chk(quad_err == 2'b01, "R6", 32'(quad_err), 32'h1);
        chk(quad_err[1] == 1'b0, "R4", 32'(quad_err), 32'h1);
        resync_quad[0] = 1'b1;
        step();
        chk(quad_err[0] == 1'b0, "R6", 32'(quad_err), 32'h0);
        chk(quad_aligned[1] == 1'b1, "R8", 32'(quad_aligned), 32'h2);

        repeat (4) step();
        chk(q.size() == 0, "scoreboard", 32'(q.size()), 32'h0);
        summary_and_end();
    end

endmodule